// File: doc/BRIEF.md
# Bracket-Scanning Tape Machine Core

This block is a small multi-cycle processor. Its machine language is the eight-symbol tape language: move the cell pointer right or left, increment or decrement the current cell, emit the cell as a byte, read a byte into the cell, and open or close a loop. Program and data live in separate memories. A program counter addresses a read-only program port that returns one opcode byte per address. A cell pointer addresses a byte-wide read/write tape memory. Both memories sit outside the core and are read combinationally.

Loops are resolved at run time with no return stack and no pre-processing of the program. Consider an opening bracket met on a zero cell. The core walks forward one opcode per cycle and keeps a nesting depth count until it finds the partner bracket. A closing bracket met on a nonzero cell is handled the same way, walking backward. Byte output and byte input each use a handshake, and the core stalls until the environment responds.

After reset the core first writes zero to every tape cell, one cell per cycle. Only then does it fetch from address 0. Each opcode takes several clock cycles, set by a nine-state controller.

Top module: `bracket_scan_core`

## Requirements
- R1: While reset is held and during the clear sweep that follows it, `progAddr` is 0, `outValid` and `halted` are 0 and `tapeWe` is 1. The sweep writes 0 to every one of the 2^ADDR_W tape cells before the first opcode runs.
- R2: Opcode 0x2B adds one to the current cell and 0x2D subtracts one, both modulo 256.
- R3: Opcode 0x3E increments the cell pointer and 0x3C decrements it, both modulo 2^ADDR_W. The pointer drives `tapeAddr`.
- R4: Opcode 0x2E puts the current cell on `outData` and raises `outValid`. Both stay unchanged until `outAck` is sampled high. `outValid` then falls and execution continues with the next opcode.
- R5: Opcode 0x2C raises `inReq` and stalls, with the program counter unchanged, until `inAck` is sampled high. It then stores `inData` in the current cell.
- R6: Opcode 0x5B on a zero cell sets the depth count to 1 and scans forward from the next opcode. During the scan, 0x5B adds one to the depth and 0x5D subtracts one. When the depth reaches zero, execution resumes at the opcode after the matching 0x5D.
- R7: Opcode 0x5D on a nonzero cell scans backward from the previous opcode. During this scan, 0x5D adds one to the depth and 0x5B subtracts one. When the depth reaches zero, execution resumes at the opcode after the matching 0x5B.
- R8: Opcode 0x5B on a nonzero cell, and 0x5D on a zero cell, simply move on to the next opcode.
- R9: Opcode 0x00 stops the core. This also applies when 0x00 is met during a bracket scan. `halted` then stays high and `progAddr` stays fixed until reset.
- R10: Any byte other than the eight opcodes and 0x00 changes neither the cell nor the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| progAddr | output | PC_W | Program counter, drives program memory address |
| progData | input | 8 | Opcode byte at `progAddr` |
| tapeAddr | output | ADDR_W | Cell pointer, drives tape memory address |
| tapeRdData | input | 8 | Tape byte at `tapeAddr` |
| tapeWrData | output | 8 | Registered write data |
| tapeWe | output | 1 | Registered write enable |
| outData | output | 8 | Output byte |
| outValid | output | 1 | Output byte is valid |
| outAck | input | 1 | Environment has taken the output byte |
| inData | input | 8 | Input byte |
| inReq | output | 1 | Core is waiting for an input byte |
| inAck | input | 1 | `inData` is valid, store it |
| halted | output | 1 | Core has stopped on 0x00 |

## Verification
The bench builds the core with ADDR_W = 6 and PC_W = 8. The tape is then 64 cells, so the clear sweep ends within 64 cycles and every cell can be read back from the bench memory model. Pointer wrap in both directions takes only a few opcodes, and programs with nested loops fit easily in a 256-byte program space. The same parameters also let the bench test handshake stalls and a scan that stops on 0x00.

// File: rtl/bsc_pkg.sv
package bsc_pkg;

  typedef enum logic [3:0] {
    ST_CLEAR, ST_FETCH, ST_EXEC, ST_WRITE, ST_OUT,
    ST_IN, ST_SKIPF, ST_SKIPB, ST_HALT
  } state_t;

  typedef enum logic [1:0] {WR_ZERO, WR_INC, WR_DEC, WR_IN} wrSel_t;

  typedef struct packed {
    logic   ptrInc;
    logic   ptrDec;
    logic   loadOp;
    logic   wrStart;
    logic   wrStop;
    wrSel_t wrSel;
    logic   outLoad;
  } strobes_t;

  localparam logic [7:0] OP_RIGHT = 8'h3E;
  localparam logic [7:0] OP_LEFT  = 8'h3C;
  localparam logic [7:0] OP_INC   = 8'h2B;
  localparam logic [7:0] OP_DEC   = 8'h2D;
  localparam logic [7:0] OP_OUT   = 8'h2E;
  localparam logic [7:0] OP_IN    = 8'h2C;
  localparam logic [7:0] OP_OPEN  = 8'h5B;
  localparam logic [7:0] OP_CLOSE = 8'h5D;
  localparam logic [7:0] OP_STOP  = 8'h00;

endpackage

// File: rtl/bsc_datapath.sv
module bsc_datapath
  import bsc_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strobes,
  input  logic [7:0]        progData,
  input  logic [7:0]        tapeRdData,
  input  logic [7:0]        inData,
  output logic [7:0]        opcode,
  output logic              cellZero,
  output logic              ptrAtMax,
  output logic [ADDR_W-1:0] tapeAddr,
  output logic [7:0]        tapeWrData,
  output logic              tapeWe,
  output logic [7:0]        outData
);

  logic [ADDR_W-1:0] ptr;
  logic [7:0]        wrReg;
  logic              weReg;
  logic [7:0]        opReg;
  logic [7:0]        outReg;
  logic [7:0]        nextVal;

  always_comb begin
    unique case (strobes.wrSel)
      WR_INC:  nextVal = tapeRdData + 8'd1;
      WR_DEC:  nextVal = tapeRdData - 8'd1;
      WR_IN:   nextVal = inData;
      default: nextVal = 8'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr    <= '0;
      weReg  <= 1'b1;
      wrReg  <= 8'd0;
      opReg  <= 8'd0;
      outReg <= 8'd0;
    end else begin
      if (strobes.ptrInc)      ptr <= ptr + 1'b1;
      else if (strobes.ptrDec) ptr <= ptr - 1'b1;
      if (strobes.loadOp) opReg <= progData;
      if (strobes.wrStart) begin
        weReg <= 1'b1;
        wrReg <= nextVal;
      end else if (strobes.wrStop) begin
        weReg <= 1'b0;
      end
      if (strobes.outLoad) outReg <= tapeRdData;
    end
  end

  assign opcode     = opReg;
  assign cellZero   = (tapeRdData == 8'd0);
  assign ptrAtMax   = &ptr;
  assign tapeAddr   = ptr;
  assign tapeWrData = wrReg;
  assign tapeWe     = weReg;
  assign outData    = outReg;

  // R3: the pointer only ever moves by one step, wrapping at the ends
  a_r3_ptr_step: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(ptr) |-> (ptr == $past(ptr) + 1'b1) || (ptr == $past(ptr) - 1'b1));

endmodule

// File: rtl/bsc_control.sv
module bsc_control
  import bsc_pkg::*;
#(
  parameter int PC_W    = 12,
  parameter int DEPTH_W = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [7:0]      opcode,
  input  logic [7:0]      progData,
  input  logic            cellZero,
  input  logic            ptrAtMax,
  input  logic            outAck,
  input  logic            inAck,
  output strobes_t        strobes,
  output logic [PC_W-1:0] pc,
  output logic            outValid,
  output logic            inReq,
  output logic            halted
);

  localparam logic [DEPTH_W-1:0] DEPTH_ONE = DEPTH_W'(1);

  state_t            state, nState;
  logic [PC_W-1:0]   pcN;
  logic [DEPTH_W-1:0] depth, depthN;
  logic              validN;

  always_comb begin
    strobes = '0;
    nState  = state;
    pcN     = pc;
    depthN  = depth;
    validN  = outValid;
    unique case (state)
      ST_CLEAR: begin
        strobes.ptrInc = 1'b1;
        if (ptrAtMax) begin
          strobes.wrStop = 1'b1;
          nState = ST_FETCH;
        end
      end
      ST_FETCH: begin
        strobes.loadOp = 1'b1;
        nState = ST_EXEC;
      end
      ST_EXEC: begin
        nState = ST_FETCH;
        pcN    = pc + 1'b1;
        case (opcode)
          OP_RIGHT: strobes.ptrInc = 1'b1;
          OP_LEFT:  strobes.ptrDec = 1'b1;
          OP_INC: begin
            strobes.wrStart = 1'b1;
            strobes.wrSel   = WR_INC;
            nState = ST_WRITE;
            pcN    = pc;
          end
          OP_DEC: begin
            strobes.wrStart = 1'b1;
            strobes.wrSel   = WR_DEC;
            nState = ST_WRITE;
            pcN    = pc;
          end
          OP_OUT: begin
            strobes.outLoad = 1'b1;
            validN = 1'b1;
            nState = ST_OUT;
            pcN    = pc;
          end
          OP_IN: begin
            nState = ST_IN;
            pcN    = pc;
          end
          OP_OPEN: begin
            if (cellZero) begin
              depthN = DEPTH_ONE;
              nState = ST_SKIPF;
            end
          end
          OP_CLOSE: begin
            if (!cellZero) begin
              depthN = DEPTH_ONE;
              nState = ST_SKIPB;
              pcN    = pc - 1'b1;
            end
          end
          OP_STOP: begin
            nState = ST_HALT;
            pcN    = pc;
          end
          default: ;
        endcase
      end
      ST_WRITE: begin
        strobes.wrStop = 1'b1;
        pcN    = pc + 1'b1;
        nState = ST_FETCH;
      end
      ST_OUT: begin
        if (outAck) begin
          validN = 1'b0;
          pcN    = pc + 1'b1;
          nState = ST_FETCH;
        end
      end
      ST_IN: begin
        if (inAck) begin
          strobes.wrStart = 1'b1;
          strobes.wrSel   = WR_IN;
          nState = ST_WRITE;
        end
      end
      ST_SKIPF: begin
        pcN = pc + 1'b1;
        if (progData == OP_OPEN) begin
          depthN = depth + 1'b1;
        end else if (progData == OP_CLOSE) begin
          depthN = depth - 1'b1;
          if (depth == DEPTH_ONE) nState = ST_FETCH;
        end else if (progData == OP_STOP) begin
          pcN    = pc;
          nState = ST_HALT;
        end
      end
      ST_SKIPB: begin
        pcN = pc - 1'b1;
        if (progData == OP_CLOSE) begin
          depthN = depth + 1'b1;
        end else if (progData == OP_OPEN) begin
          depthN = depth - 1'b1;
          if (depth == DEPTH_ONE) begin
            pcN    = pc + 1'b1;
            nState = ST_FETCH;
          end
        end else if (progData == OP_STOP) begin
          pcN    = pc;
          nState = ST_HALT;
        end
      end
      ST_HALT: ;
      default: nState = ST_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_CLEAR;
      pc       <= '0;
      depth    <= '0;
      outValid <= 1'b0;
    end else begin
      state    <= nState;
      pc       <= pcN;
      depth    <= depthN;
      outValid <= validN;
    end
  end

  assign inReq  = (state == ST_IN);
  assign halted = (state == ST_HALT);

  // R1: no fetch or output while the tape is being cleared
  a_r1_clear_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CLEAR) |-> (pc == '0) && !outValid);

  // R4: an unacknowledged output byte keeps its valid flag
  a_r4_valid_hold: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outAck |=> outValid);

  // R5: the input stall holds the program counter
  a_r5_in_stall: assert property (@(posedge clk) disable iff (!rstN)
    inReq && !inAck |=> inReq && $stable(pc));

  // R9: once stopped the core stays stopped
  a_r9_halt_sticky: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> halted && $stable(pc));

  // R6: a forward scan never moves the program counter backward
  a_r6_fwd_scan: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SKIPF) && (nState == ST_SKIPF) |=> pc == $past(pc) + 1'b1);

endmodule

// File: rtl/bracket_scan_core.sv
module bracket_scan_core
  import bsc_pkg::*;
#(
  parameter int ADDR_W  = 15,
  parameter int PC_W    = 12,
  parameter int DEPTH_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  output logic [PC_W-1:0]   progAddr,
  input  logic [7:0]        progData,
  output logic [ADDR_W-1:0] tapeAddr,
  input  logic [7:0]        tapeRdData,
  output logic [7:0]        tapeWrData,
  output logic              tapeWe,
  output logic [7:0]        outData,
  output logic              outValid,
  input  logic              outAck,
  input  logic [7:0]        inData,
  output logic              inReq,
  input  logic              inAck,
  output logic              halted
);

  strobes_t   strobes;
  logic [7:0] opcode;
  logic       cellZero;
  logic       ptrAtMax;

  bsc_control #(.PC_W(PC_W), .DEPTH_W(DEPTH_W)) u_control (
    .clk(clk), .rstN(rstN), .opcode(opcode), .progData(progData),
    .cellZero(cellZero), .ptrAtMax(ptrAtMax), .outAck(outAck), .inAck(inAck),
    .strobes(strobes), .pc(progAddr), .outValid(outValid), .inReq(inReq),
    .halted(halted)
  );

  bsc_datapath #(.ADDR_W(ADDR_W)) u_datapath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .progData(progData),
    .tapeRdData(tapeRdData), .inData(inData), .opcode(opcode),
    .cellZero(cellZero), .ptrAtMax(ptrAtMax), .tapeAddr(tapeAddr),
    .tapeWrData(tapeWrData), .tapeWe(tapeWe), .outData(outData)
  );

  // R4: the output byte does not change while it waits for acknowledge
  a_r4_data_stable: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outAck |=> $stable(outData));

endmodule

// File: tb/bracket_scan_core_tb.sv
module bracket_scan_core_tb;

  localparam int ADDR_W = 6;
  localparam int PC_W   = 8;
  localparam int CELLS  = 1 << ADDR_W;
  localparam int ROMSZ  = 1 << PC_W;

  typedef struct packed {
    logic [159:0] prog;
    logic [7:0]   inByte;
    logic [3:0]   nOut;
    logic [31:0]  expOut;
  } vec_t;

  localparam int NVEC = 11;
  localparam vec_t VECS [NVEC] = '{
    '{"+++.",                 8'h00, 4'd1, 32'h0300_0000}, // R2 R4
    '{"-.",                   8'h00, 4'd1, 32'hFF00_0000}, // R2 wrap below zero
    '{",+.",                  8'h41, 4'd1, 32'h4200_0000}, // R5
    '{"[+.]+.",               8'h00, 4'd1, 32'h0100_0000}, // R6
    '{"[[]+.]+.",             8'h00, 4'd1, 32'h0100_0000}, // R6 nested
    '{"+++[>++<-]>.",         8'h00, 4'd1, 32'h0600_0000}, // R7
    '{"++[>+++[>+<-]<-]>>.",  8'h00, 4'd1, 32'h0600_0000}, // R7 nested
    '{"<+.>.",                8'h00, 4'd2, 32'h0100_0000}, // R3 R1
    '{"+[.-].",               8'h00, 4'd2, 32'h0100_0000}, // R8
    '{"a+ z.",                8'h00, 4'd1, 32'h0100_0000}, // R10
    '{"+>++>+++<<.>.>.",      8'h00, 4'd3, 32'h0102_0300}  // R3
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [PC_W-1:0]   progAddr;
  logic [7:0]        progData;
  logic [ADDR_W-1:0] tapeAddr;
  logic [7:0]        tapeRdData;
  logic [7:0]        tapeWrData;
  logic              tapeWe;
  logic [7:0]        outData;
  logic              outValid;
  logic              outAck = 1'b0;
  logic [7:0]        inData = 8'h00;
  logic              inReq;
  logic              inAck = 1'b0;
  logic              halted;

  logic [7:0] rom [ROMSZ];
  logic [7:0] mem [CELLS];

  int nChecks = 0;
  int nErrors = 0;
  int cycles  = 0;
  logic [7:0] got [8];
  int gotCount;

  always #2 clk = ~clk;

  bracket_scan_core #(.ADDR_W(ADDR_W), .PC_W(PC_W), .DEPTH_W(8)) u_dut (
    .clk(clk), .rstN(rstN), .progAddr(progAddr), .progData(progData),
    .tapeAddr(tapeAddr), .tapeRdData(tapeRdData), .tapeWrData(tapeWrData),
    .tapeWe(tapeWe), .outData(outData), .outValid(outValid), .outAck(outAck),
    .inData(inData), .inReq(inReq), .inAck(inAck), .halted(halted)
  );

  assign progData   = rom[progAddr];
  assign tapeRdData = mem[tapeAddr];

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (tapeWe) mem[tapeAddr] <= tapeWrData;
  end

  always @(negedge clk) begin
    if (cycles > 150000) begin
      nErrors++;
      $display("FAIL watchdog: actual %0d cycles expected under 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic loadProg(input logic [159:0] p);
    int idx = 0;
    bit started = 0;
    for (int i = 0; i < ROMSZ; i++) rom[i] = 8'h00;
    for (int i = 19; i >= 0; i--) begin
      if (p[i*8 +: 8] != 8'h00) started = 1;
      if (started) begin
        rom[idx] = p[i*8 +: 8];
        idx++;
      end
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    for (int i = 0; i < CELLS; i++) mem[i] = 8'hA5;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic runToHalt(input int limit);
    gotCount = 0;
    for (int c = 0; c < limit && !halted; c++) begin
      @(negedge clk);
      if (outValid && outAck && gotCount < 8) begin
        got[gotCount] = outData;
        gotCount++;
      end
    end
  endtask

  initial begin
    // R1: reset state
    loadProg("+.");
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    check(progAddr == 0, "R1 reset progAddr", progAddr, 0);
    check(!outValid, "R1 reset outValid", outValid, 0);
    check(!halted, "R1 reset halted", halted, 0);
    check(tapeWe, "R1 reset tapeWe", tapeWe, 1);

    // vector table
    for (int v = 0; v < NVEC; v++) begin
      loadProg(VECS[v].prog);
      inData = VECS[v].inByte;
      inAck  = 1'b1;
      outAck = 1'b1;
      doReset();
      runToHalt(5000);
      check(halted, "R9 vector halts", halted, 1);
      check(gotCount == int'(VECS[v].nOut), "R4 vector byte count", gotCount, VECS[v].nOut);
      for (int k = 0; k < int'(VECS[v].nOut) && k < gotCount; k++)
        check(got[k] == VECS[v].expOut[31-8*k -: 8], "R2/R6/R7 vector byte",
              got[k], VECS[v].expOut[31-8*k -: 8]);
    end

    // R1: clear sweep zeroes every cell, R9 empty program halts at 0
    loadProg(160'h0);
    doReset();
    runToHalt(500);
    check(halted && progAddr == 0, "R9 halt at start", progAddr, 0);
    begin
      int bad = 0;
      for (int i = 0; i < CELLS; i++) if (mem[i] != 8'h00) bad++;
      check(bad == 0, "R1 cleared cells", bad, 0);
    end
    repeat (20) @(negedge clk);
    check(halted && progAddr == 0, "R9 halt sticky", progAddr, 0);

    // R4: output stall
    loadProg("++.");
    outAck = 1'b0;
    doReset();
    for (int c = 0; c < 500 && !outValid; c++) @(negedge clk);
    repeat (10) @(negedge clk);
    check(outValid, "R4 valid held", outValid, 1);
    check(outData == 8'd2, "R4 data held", outData, 2);
    check(progAddr == 2, "R4 pc held", progAddr, 2);
    outAck = 1'b1;
    @(negedge clk);
    check(!outValid, "R4 valid drops after ack", outValid, 0);
    runToHalt(100);
    check(halted, "R4 resumes", halted, 1);

    // R5: input stall
    loadProg(",.");
    inAck = 1'b0;
    doReset();
    repeat (150) @(negedge clk);
    check(inReq, "R5 inReq while waiting", inReq, 1);
    check(progAddr == 0 && !halted, "R5 stalled pc", progAddr, 0);
    inData = 8'h07;
    inAck  = 1'b1;
    runToHalt(100);
    check(gotCount == 1 && got[0] == 8'h07, "R5 stored byte", got[0], 7);

    // R9: unmatched forward scan stops on 0x00
    loadProg("[+");
    doReset();
    runToHalt(500);
    check(halted, "R9 scan halts", halted, 1);
    check(progAddr == 2, "R9 scan halt address", progAddr, 2);
    check(gotCount == 0, "R9 no output", gotCount, 0);

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

endmodule